// File: doc/BRIEF.md
# Authenticated-Cipher Output Formatter

This block sits behind an authenticated-cipher datapath and builds the final output word stream of each message. A command gives the direction and the byte length of the message. The formatter first passes a header word and its associated-data words, taken from a bypass FIFO, to the output unchanged. It then writes a data segment header and the message data. The data arrives from the cipher core as full-width blocks, each with a count of valid bytes. The formatter clears every byte beyond that count and splits the block into W-bit words.

When encrypting, the ciphertext words go straight to the output. A tag segment and a success status word follow them. When decrypting, the plaintext words go into an auxiliary FIFO and wait for the tag verdict. If the tag is good, the formatter writes the plaintext header, drains the FIFO to the output and writes a success status. If the tag is bad, the FIFO is cleared without emitting anything and a single error status word is written. Only one message is processed at a time.

The control is one state machine:

| State | Role |
|---|---|
| S_IDLE | Waits for a command. |
| S_BP_HDR | Forwards the bypass header. |
| S_BP_DATA | Forwards the associated-data words. |
| S_SEG_HDR | Writes the ciphertext header. |
| S_DATA | Accepts and serializes blocks. |
| S_TAG_HDR | Writes the tag header. |
| S_TAG | Serializes the tag. |
| S_AUTH | Waits for the verdict. |
| S_PT_HDR | Writes the plaintext header. |
| S_DRAIN | Empties the auxiliary FIFO to the output. |
| S_FLUSH | Clears the auxiliary FIFO. |
| S_STATUS | Writes the status word. |

Transitions:

- S_IDLE→S_BP_HDR on an accepted command.
- S_BP_HDR→S_BP_DATA when the bypass count is non-zero. Otherwise it goes to the data phase.
- S_BP_DATA→data phase after the last bypass word.
- The data phase is S_SEG_HDR→S_DATA when encrypting, or S_DATA directly when decrypting.
- S_DATA→S_TAG_HDR (encrypt) or S_AUTH (decrypt) once all bytes are taken and the serializer is empty.
- S_TAG_HDR→S_TAG, then S_TAG→S_STATUS.
- S_AUTH→S_PT_HDR on a pass, or S_AUTH→S_FLUSH on a fail.
- S_PT_HDR→S_DRAIN, then S_DRAIN→S_STATUS when the FIFO is empty.
- S_FLUSH→S_STATUS.
- S_STATUS→S_IDLE once the status word is accepted.

Top module: `aead_outfmt`

## Requirements
- R1: After reset, do_valid is low and cmd_ready is high. byp_ready, blk_ready, tag_ready and auth_ready are all low.
- R2: The first bypass word of a message is forwarded unchanged. Its low LENW bits give a byte count n. The next ceil(n/(W/8)) bypass words are also forwarded unchanged, in order.
- R3: A data segment header has its type in bits [W-1:W-4]: 4'h5 for ciphertext, 4'h4 for plaintext. It carries the message byte length in bits [LENW-1:0]. All its other bits are zero. It comes directly before the data words.
- R4: A block with blk_bytes = k produces ceil(k/(W/8)) output words. Block byte i occupies bits [BLKW-1-8i -: 8]. The first word is the top W bits of the block, and later words follow in descending bit order.
- R5: Every byte position at or beyond blk_bytes in a block is output as zero.
- R6: During decryption, no plaintext header or plaintext word is output before a passing verdict, and nothing is output while the verdict is awaited. On a pass, the status word is success.
- R7: On a failing verdict, no plaintext word is output and the auxiliary FIFO is emptied. Exactly one status word is output: bits [W-1:W-4] = 4'hE, bit 0 = 1, all other bits zero.
- R8: When encrypting, a tag header follows the data: type 4'h8, length TAGW/8. The TAGW/W tag words follow, most significant first. Then comes a success status word: 4'hE in the top four bits, all other bits zero.
- R9: While do_valid is high and do_ready is low, do_valid stays high and do_data stays unchanged on the next cycle.
- R10: blk_ready is high only while the serializer holds no words. The next block is therefore accepted only after the previous one has fully left the serializer.
- R11: cmd_ready is high only in the idle state, and nothing is output while idle. After a message's status word, the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Message command offered |
| cmd_ready | output | 1 | Command accepted (idle) |
| cmd_decrypt | input | 1 | 1 = decryption, 0 = encryption |
| cmd_len | input | LENW | Message length in bytes |
| byp_data | input | W | Bypass FIFO word |
| byp_valid | input | 1 | Bypass word available |
| byp_ready | output | 1 | Bypass word taken |
| blk_data | input | BLKW | Result block from the cipher core |
| blk_bytes | input | $clog2(BLKW/8+1) | Valid bytes in the block |
| blk_valid | input | 1 | Block offered |
| blk_ready | output | 1 | Block taken |
| tag_data | input | TAGW | Computed tag |
| tag_valid | input | 1 | Tag offered |
| tag_ready | output | 1 | Tag taken |
| auth_valid | input | 1 | Tag verdict offered |
| auth_pass | input | 1 | 1 = tag matched |
| auth_ready | output | 1 | Verdict taken |
| do_data | output | W | Output word |
| do_valid | output | 1 | Output word valid |
| do_ready | input | 1 | Output word accepted |

## Verification
The bench builds the formatter with 16-bit words, 64-bit blocks, a 32-bit tag, an eight-word auxiliary FIFO and 8-bit length fields. With these values every message length from zero up to the full FIFO capacity of 16 bytes can be swept. The sweep runs in all three modes: encrypt, decrypt with a pass, and decrypt with a fail. It uses several associated-data lengths. The two-byte words and eight-byte blocks mean the sweep covers even and odd tails, partial final blocks and multi-block messages. A pseudo-random stall pattern on do_ready exercises serializer backpressure and the hold rule.

// File: rtl/aead_outfmt_pkg.sv
package aead_outfmt_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_BP_HDR,
        S_BP_DATA,
        S_SEG_HDR,
        S_DATA,
        S_TAG_HDR,
        S_TAG,
        S_AUTH,
        S_PT_HDR,
        S_DRAIN,
        S_FLUSH,
        S_STATUS
    } fmt_state_e;

    localparam logic [3:0] TY_CIPHER = 4'h5;
    localparam logic [3:0] TY_PLAIN  = 4'h4;
    localparam logic [3:0] TY_TAG    = 4'h8;
    localparam logic [3:0] TY_STATUS = 4'hE;

endpackage

// File: rtl/aead_outfmt_mask.sv
module aead_outfmt_mask #(
    parameter int BLKW = 128,
    localparam int NB  = BLKW / 8,
    localparam int BBW = $clog2(NB + 1)
) (
    input  logic [BLKW-1:0] raw,
    input  logic [BBW-1:0]  keep,
    output logic [BLKW-1:0] clean
);
    for (genvar i = 0; i < NB; i++) begin : g_byte
        localparam logic [BBW-1:0] IDX = BBW'(i);
        assign clean[BLKW-1-8*i -: 8] = (IDX < keep) ? raw[BLKW-1-8*i -: 8] : 8'h00;
    end
endmodule

// File: rtl/aead_outfmt_piso.sv
module aead_outfmt_piso #(
    parameter int BLKW = 128,
    parameter int W    = 32,
    localparam int WPB = BLKW / W,
    localparam int CW  = $clog2(WPB + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BLKW-1:0] load_data,
    input  logic [CW-1:0]   load_words,
    input  logic            adv,
    output logic            out_valid,
    output logic [W-1:0]    out_word,
    output logic [CW-1:0]   left
);
    logic [BLKW-1:0] sr_q;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sr_q  <= load_data;
            cnt_q <= load_words;
        end else if (adv && cnt_q != '0) begin
            sr_q  <= sr_q << W;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign out_valid = (cnt_q != '0);
    assign out_word  = sr_q[BLKW-1 -: W];
    assign left      = cnt_q;
endmodule

// File: rtl/aead_outfmt_fifo.sv
module aead_outfmt_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full,
    output logic [AW:0]  count
);
    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp_q, rp_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (wr && !full)  wp_q <= wp_q + 1'b1;
            if (rd && !empty) rp_q <= rp_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr && !full) mem[wp_q[AW-1:0]] <= wdata;
    end

    assign rdata = mem[rp_q[AW-1:0]];
    assign empty = (wp_q == rp_q);
    assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
    assign count = wp_q - rp_q;
endmodule

// File: rtl/aead_outfmt.sv
module aead_outfmt
    import aead_outfmt_pkg::*;
#(
    parameter int W         = 32,
    parameter int BLKW      = 128,
    parameter int TAGW      = 128,
    parameter int AUX_DEPTH = 16,
    parameter int LENW      = 16,
    localparam int BPW      = W / 8,
    localparam int BPB      = BLKW / 8,
    localparam int WPB      = BLKW / W,
    localparam int TAG_B    = TAGW / 8,
    localparam int TAG_WDS  = TAGW / W,
    localparam int BBW      = $clog2(BPB + 1),
    localparam int CW       = $clog2(WPB + 1),
    localparam int AW       = $clog2(AUX_DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic            cmd_decrypt,
    input  logic [LENW-1:0] cmd_len,
    input  logic [W-1:0]    byp_data,
    input  logic            byp_valid,
    output logic            byp_ready,
    input  logic [BLKW-1:0] blk_data,
    input  logic [BBW-1:0]  blk_bytes,
    input  logic            blk_valid,
    output logic            blk_ready,
    input  logic [TAGW-1:0] tag_data,
    input  logic            tag_valid,
    output logic            tag_ready,
    input  logic            auth_valid,
    input  logic            auth_pass,
    output logic            auth_ready,
    output logic [W-1:0]    do_data,
    output logic            do_valid,
    input  logic            do_ready
);

    function automatic logic [W-1:0] seg_word(input logic [3:0] ty, input logic [LENW-1:0] n);
        logic [W-1:0] r;
        r = '0;
        r[W-1 -: 4]   = ty;
        r[LENW-1:0]   = n;
        return r;
    endfunction

    function automatic logic [W-1:0] stat_word(input logic bad);
        logic [W-1:0] r;
        r = '0;
        r[W-1 -: 4] = TY_STATUS;
        r[0]        = bad;
        return r;
    endfunction

    function automatic logic [LENW-1:0] words_of(input logic [LENW-1:0] n);
        return LENW'((int'(n) + BPW - 1) / BPW);
    endfunction

    fmt_state_e      st_q, st_nx;
    logic            dec_q, fail_q, tag_ld_q;
    logic [LENW-1:0] len_q, remain_q, bcnt_q;

    // serializer and buffer wiring
    logic            piso_load, piso_adv, piso_valid;
    logic [W-1:0]    piso_word;
    logic [CW-1:0]   piso_cnt, load_words;
    logic [BLKW-1:0] mask_in, mask_out, tag_pad;
    logic [BBW-1:0]  mask_keep;
    logic            aux_wr, aux_rd, aux_clr, aux_empty, aux_full;
    logic [W-1:0]    aux_rdata;
    logic [AW:0]     aux_cnt;
    fmt_state_e      after_bp;

    assign tag_pad   = BLKW'(tag_data) << (BLKW - TAGW);
    assign mask_in   = (st_q == S_TAG) ? tag_pad : blk_data;
    assign mask_keep = (st_q == S_TAG) ? BBW'(TAG_B) : blk_bytes;
    assign load_words = (st_q == S_TAG) ? CW'(TAG_WDS)
                                        : CW'((int'(blk_bytes) + BPW - 1) / BPW);
    assign after_bp  = dec_q ? S_DATA : S_SEG_HDR;

    aead_outfmt_mask #(.BLKW(BLKW)) u_mask (
        .raw   (mask_in),
        .keep  (mask_keep),
        .clean (mask_out)
    );

    aead_outfmt_piso #(.BLKW(BLKW), .W(W)) u_piso (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (piso_load),
        .load_data  (mask_out),
        .load_words (load_words),
        .adv        (piso_adv),
        .out_valid  (piso_valid),
        .out_word   (piso_word),
        .left       (piso_cnt)
    );

    aead_outfmt_fifo #(.W(W), .DEPTH(AUX_DEPTH)) u_aux (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (aux_clr),
        .wr    (aux_wr),
        .wdata (piso_word),
        .rd    (aux_rd),
        .rdata (aux_rdata),
        .empty (aux_empty),
        .full  (aux_full),
        .count (aux_cnt)
    );

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            S_IDLE:    if (cmd_valid) st_nx = S_BP_HDR;
            S_BP_HDR:  if (byp_valid && do_ready)
                           st_nx = (words_of(byp_data[LENW-1:0]) != '0) ? S_BP_DATA : after_bp;
            S_BP_DATA: if (byp_valid && do_ready && bcnt_q == LENW'(1)) st_nx = after_bp;
            S_SEG_HDR: if (do_ready) st_nx = S_DATA;
            S_DATA:    if (remain_q == '0 && piso_cnt == '0)
                           st_nx = dec_q ? S_AUTH : S_TAG_HDR;
            S_TAG_HDR: if (do_ready) st_nx = S_TAG;
            S_TAG:     if (tag_ld_q && piso_cnt == '0) st_nx = S_STATUS;
            S_AUTH:    if (auth_valid) st_nx = auth_pass ? S_PT_HDR : S_FLUSH;
            S_PT_HDR:  if (do_ready) st_nx = S_DRAIN;
            S_DRAIN:   if (aux_empty) st_nx = S_STATUS;
            S_FLUSH:   st_nx = S_STATUS;
            S_STATUS:  if (do_ready) st_nx = S_IDLE;
            default:   st_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_nx;
    end

    // outputs
    always_comb begin
        cmd_ready  = 1'b0;
        byp_ready  = 1'b0;
        blk_ready  = 1'b0;
        tag_ready  = 1'b0;
        auth_ready = 1'b0;
        do_valid   = 1'b0;
        do_data    = '0;
        piso_load  = 1'b0;
        piso_adv   = 1'b0;
        aux_wr     = 1'b0;
        aux_rd     = 1'b0;
        aux_clr    = 1'b0;
        unique case (st_q)
            S_IDLE: cmd_ready = 1'b1;
            S_BP_HDR, S_BP_DATA: begin
                do_valid  = byp_valid;
                do_data   = byp_data;
                byp_ready = do_ready;
            end
            S_SEG_HDR: begin
                do_valid = 1'b1;
                do_data  = seg_word(TY_CIPHER, len_q);
            end
            S_DATA: begin
                blk_ready = (piso_cnt == '0) && (remain_q != '0);
                piso_load = blk_valid && blk_ready;
                if (dec_q) begin
                    aux_wr   = piso_valid && !aux_full;
                    piso_adv = aux_wr;
                end else begin
                    do_valid = piso_valid;
                    do_data  = piso_word;
                    piso_adv = piso_valid && do_ready;
                end
            end
            S_TAG_HDR: begin
                do_valid = 1'b1;
                do_data  = seg_word(TY_TAG, LENW'(TAG_B));
            end
            S_TAG: begin
                tag_ready = !tag_ld_q;
                piso_load = tag_valid && tag_ready;
                do_valid  = piso_valid;
                do_data   = piso_word;
                piso_adv  = piso_valid && do_ready;
            end
            S_AUTH: auth_ready = 1'b1;
            S_PT_HDR: begin
                do_valid = 1'b1;
                do_data  = seg_word(TY_PLAIN, len_q);
            end
            S_DRAIN: begin
                do_valid = !aux_empty;
                do_data  = aux_rdata;
                aux_rd   = do_valid && do_ready;
            end
            S_FLUSH: aux_clr = 1'b1;
            S_STATUS: begin
                do_valid = 1'b1;
                do_data  = stat_word(fail_q);
            end
            default: ;
        endcase
    end

    // message bookkeeping registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q    <= 1'b0;
            fail_q   <= 1'b0;
            tag_ld_q <= 1'b0;
            len_q    <= '0;
            remain_q <= '0;
            bcnt_q   <= '0;
        end else begin
            if (st_q == S_IDLE && cmd_valid) begin
                dec_q    <= cmd_decrypt;
                len_q    <= cmd_len;
                remain_q <= cmd_len;
                fail_q   <= 1'b0;
                tag_ld_q <= 1'b0;
            end
            if (st_q == S_BP_HDR && byp_valid && do_ready)
                bcnt_q <= words_of(byp_data[LENW-1:0]);
            if (st_q == S_BP_DATA && byp_valid && do_ready)
                bcnt_q <= bcnt_q - 1'b1;
            if (st_q == S_DATA && piso_load) begin
                if (LENW'(blk_bytes) >= remain_q) remain_q <= '0;
                else                             remain_q <= remain_q - LENW'(blk_bytes);
            end
            if (st_q == S_TAG && piso_load) tag_ld_q <= 1'b1;
            if (st_q == S_AUTH && auth_valid) fail_q <= !auth_pass;
        end
    end

endmodule

// File: rtl/aead_outfmt_chk.sv
module aead_outfmt_chk #(
    parameter int W    = 32,
    parameter int CW   = 3,
    parameter int CNTW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_ready,
    input logic            blk_ready,
    input logic            auth_valid,
    input logic            auth_ready,
    input logic            auth_pass,
    input logic            do_valid,
    input logic            do_ready,
    input logic [W-1:0]    do_data,
    input logic [CW-1:0]   piso_cnt,
    input logic [CNTW-1:0] aux_cnt
);
    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_valid && !do_ready) |=> (do_valid && $stable(do_data)));

    // R10
    blk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_ready |-> (piso_cnt == '0));

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auth_valid && auth_ready && !auth_pass) |=> ##1 (aux_cnt == '0));

    // R6
    verdict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auth_ready |-> !do_valid);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !do_valid);
endmodule

bind aead_outfmt aead_outfmt_chk #(.W(W), .CW(CW), .CNTW(AW + 1)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_ready  (cmd_ready),
    .blk_ready  (blk_ready),
    .auth_valid (auth_valid),
    .auth_ready (auth_ready),
    .auth_pass  (auth_pass),
    .do_valid   (do_valid),
    .do_ready   (do_ready),
    .do_data    (do_data),
    .piso_cnt   (piso_cnt),
    .aux_cnt    (aux_cnt)
);

// File: tb/aead_outfmt_test.sv
module aead_outfmt_test;
    localparam int W = 16, BLKW = 64, TAGW = 32, AUXD = 8, LENW = 8;
    localparam int BBW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0, cmd_decrypt = 0, cmd_ready;
    logic [LENW-1:0] cmd_len = '0;
    logic [W-1:0] byp_data = '0; logic byp_valid = 0, byp_ready;
    logic [BLKW-1:0] blk_data = '0; logic [BBW-1:0] blk_bytes = '0;
    logic blk_valid = 0, blk_ready;
    logic [TAGW-1:0] tag_data = '0; logic tag_valid = 0, tag_ready;
    logic auth_valid = 0, auth_pass = 0, auth_ready;
    logic [W-1:0] do_data; logic do_valid, do_ready = 0;

    aead_outfmt #(.W(W), .BLKW(BLKW), .TAGW(TAGW), .AUX_DEPTH(AUXD), .LENW(LENW)) uut (.*);

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [W-1:0] exp_w [0:63];
    string        exp_r [0:63];
    int           bstart [0:7];
    int n_exp, n_byp, recv;
    bit blocks_done;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", r, act, expv);
        end
    endtask

    function automatic logic [7:0] dbyte(input int m, input int i);
        return 8'(m * 7 + i * 13 + 1);
    endfunction

    function automatic logic [TAGW-1:0] tagv(input int m);
        return TAGW'(m * 32'h01010101) ^ 32'hC3A50F1E;
    endfunction

    task automatic push(input logic [W-1:0] w, input string r);
        exp_w[n_exp] = w; exp_r[n_exp] = r; n_exp++;
    endtask

    task automatic build(input int mode, input int m, input int ad, input int len);
        n_exp = 0;
        push(16'h2000 | 16'(ad), "R2");
        for (int k = 0; k < (ad + 1) / 2; k++) push(16'(m * 31 + k * 3 + 16'h100), "R2");
        n_byp = n_exp;
        if (mode == 2) begin
            push(16'hE001, "R7");
            return;
        end
        push((mode == 0 ? 16'h5000 : 16'h4000) | 16'(len), "R3");
        for (int b = 0; b * 8 < len; b++) begin
            int nb;
            nb = (len - b * 8 > 8) ? 8 : len - b * 8;
            bstart[b] = n_exp;
            for (int j = 0; j < (nb + 1) / 2; j++) begin
                logic [7:0] lo;
                lo = (2 * j + 1 < nb) ? dbyte(m, b * 8 + 2 * j + 1) : 8'h00;
                push({dbyte(m, b * 8 + 2 * j), lo}, (2 * j + 1 < nb) ? "R4" : "R5");
            end
        end
        if (mode == 0) begin
            push(16'h8004, "R8");
            push(tagv(m)[31:16], "R8");
            push(tagv(m)[15:0], "R8");
            push(16'hE000, "R8");
        end else push(16'hE000, "R6");
    endtask

    task automatic drive_cmd(input bit dec, input int len);
        @(negedge clk); cmd_valid = 1; cmd_decrypt = dec; cmd_len = LENW'(len);
        #1; while (!cmd_ready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk); cmd_valid = 0;
    endtask

    task automatic drive_byp(input int m, input int ad);
        for (int k = 0; k < n_byp; k++) begin
            @(negedge clk); byp_valid = 1;
            byp_data = (k == 0) ? (16'h2000 | 16'(ad)) : 16'(m * 31 + (k - 1) * 3 + 16'h100);
            #1; while (!byp_ready) begin @(negedge clk); #1; end
            @(posedge clk);
        end
        @(negedge clk); byp_valid = 0;
    endtask

    task automatic drive_blocks(input int m, input int len, input bit enc);
        for (int b = 0; b * 8 < len; b++) begin
            int nb;
            logic [BLKW-1:0] d;
            nb = (len - b * 8 > 8) ? 8 : len - b * 8;
            for (int i = 0; i < 8; i++) d[63 - 8 * i -: 8] = (i < nb) ? dbyte(m, b * 8 + i) : 8'hA5;
            @(negedge clk); blk_valid = 1; blk_data = d; blk_bytes = BBW'(nb);
            #1; while (!blk_ready) begin @(negedge clk); #1; end
            // R10: previous block fully emitted before the next is taken
            if (enc) chk(recv >= bstart[b], "R10", 32'(recv), 32'(bstart[b]));
            @(posedge clk);
        end
        @(negedge clk); blk_valid = 0;
        blocks_done = 1;
    endtask

    task automatic drive_tag(input int m);
        @(negedge clk); tag_valid = 1; tag_data = tagv(m);
        #1; while (!tag_ready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk); tag_valid = 0;
    endtask

    task automatic drive_auth(input bit pass);
        while (!blocks_done) @(negedge clk);
        repeat (6) @(negedge clk);
        #1; // R6: only bypass words may have left before the verdict
        chk(recv == n_byp, "R6", 32'(recv), 32'(n_byp));
        @(negedge clk); auth_valid = 1; auth_pass = pass;
        #1; while (!auth_ready) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk); auth_valid = 0;
    endtask

    task automatic collect();
        bit held = 0;
        logic [W-1:0] hw = '0;
        while (recv < n_exp) begin
            @(negedge clk);
            if (held) chk(do_valid && do_data == hw, "R9", {15'd0, do_valid, do_data}, {15'd0, 1'b1, hw});
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_ready = (lfsr[1:0] != 2'b00);
            #1;
            held = do_valid && !do_ready;
            hw = do_data;
            if (do_valid && do_ready) begin
                chk(do_data == exp_w[recv], exp_r[recv], 32'(do_data), 32'(exp_w[recv]));
                recv++;
            end
        end
        @(negedge clk); do_ready = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int m = 0;
        int ads [3] = '{0, 1, 4};
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!do_valid && cmd_ready, "R1", {30'd0, do_valid, cmd_ready}, 32'h1);
        chk(!byp_ready && !blk_ready && !tag_ready && !auth_ready, "R1",
            {28'd0, byp_ready, blk_ready, tag_ready, auth_ready}, 32'h0);
        for (int mode = 0; mode < 3; mode++) begin
            for (int a = 0; a < 3; a++) begin
                for (int len = 0; len <= 16; len++) begin
                    build(mode, m, ads[a], len);
                    recv = 0; blocks_done = 0;
                    fork
                        drive_cmd(mode != 0, len);
                        drive_byp(m, ads[a]);
                        drive_blocks(m, len, mode == 0);
                        begin
                            if (mode == 0) drive_tag(m);
                            else drive_auth(mode == 1);
                        end
                        collect();
                    join
                    repeat (3) @(negedge clk);
                    #1; // R11 back to idle, silent
                    chk(cmd_ready && !do_valid, "R11", {30'd0, cmd_ready, do_valid}, 32'h2);
                    m++;
                end
            end
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule